// File: doc/BRIEF.md
# Instruction Candidate Filter and Ranker

After a double-bit memory error that the check code can only detect, a set of possible original 32-bit instruction words is left. This block takes that set as a stream, one candidate per cycle, and picks the most plausible one. Any candidate that encodes an illegal instruction is dropped. An instruction is illegal when its primary opcode is reserved, when it is a register-format instruction with a reserved function code, or when it is a floating-point coprocessor instruction with a reserved format code.

When one candidate is legal, that candidate is the answer. When several are legal, the block ranks them with a programmable table of 8-bit occurrence weights and picks the heaviest. Common loads and stores are given high weights and rare operations low ones. When no candidate is legal, the block reports failure so that the system can poison the data or stop.

The legality masks and the weight tables are written through a small write-only register port. Each recovery event produces one result beat. That beat holds the chosen word, the number of legal candidates and exactly one of three outcome flags.

Top module: `icf_candidate_select`

## Requirements
- R1: After reset, res_valid is low, cand_ready is high, every opcode, funct and fmt code counts as legal, and all weights are zero.
- R2: A candidate is illegal when bit N of the 64-bit opcode mask is 0, where N is the candidate's bits 31:26. A mask bit of 1 means allowed.
- R3: When the opcode is 6'h00 (register format), the candidate is also illegal if bit F of the 64-bit funct mask is 0, where F is bits 5:0.
- R4: When the opcode is 6'h11 (floating-point coprocessor), the candidate is also illegal if bit T of the 32-bit fmt mask is 0, where T is bits 25:21.
- R5: Each result has exactly one of res_unique (count 1), res_ambig (count above 1) or res_fail (count 0) set, and res_count equals the number of legal candidates in the event.
- R6: When exactly one candidate is legal, res_word is that candidate.
- R7: When several candidates are legal, res_word is the one with the largest weight. For opcode 6'h00 the weight comes from the funct-indexed table. For any other opcode it comes from the opcode-indexed table.
- R8: Among legal candidates that share the largest weight, the one that arrived first is chosen.
- R9: When no candidate is legal, res_fail is set, res_word is zero and res_count is zero.
- R10: An event closes on an accepted beat with cand_last high, or on its 16th accepted beat. res_valid is high for one cycle, in the cycle after the closing beat.
- R11: Register writes (cfg_we high) use these addresses. 0x00 and 0x01 hold the low and high 32 bits of the opcode mask. 0x02 and 0x03 hold the low and high 32 bits of the funct mask. 0x04 holds the fmt mask. 0x40+i sets the opcode weight i from cfg_wdata[7:0], and 0x80+i sets the funct weight i the same way. Writes to any other address change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 8 | Register write address |
| cfg_wdata | input | 32 | Register write data |
| cand_valid | input | 1 | Candidate beat valid |
| cand_ready | output | 1 | Block accepts candidates |
| cand_data | input | 32 | Candidate instruction word |
| cand_last | input | 1 | Final candidate of the event |
| res_valid | output | 1 | Result beat, one cycle |
| res_word | output | 32 | Chosen instruction word (zero on failure) |
| res_unique | output | 1 | Exactly one legal candidate |
| res_ambig | output | 1 | More than one legal candidate |
| res_fail | output | 1 | No legal candidate |
| res_count | output | 5 | Number of legal candidates |

## Verification
The assertions assume two things about the inputs. First, cand_data and cand_last are stable whenever cand_valid is high at a clock edge. Second, register writes do not race a candidate that the checker is tracking. Both are easy to meet because the block takes one beat per cycle once reset is released. The stimulus drives every input on the falling edge and does all configuration between events, so each result can be predicted from a single table state. Random events mix 1 to 16 candidates, with opcodes biased toward the register-format and coprocessor codes and with mostly-legal random masks. Directed events cover reordered ties, the all-illegal case and the 16-beat close without a last flag.

// File: rtl/icf_pkg.sv
package icf_pkg;
  localparam int WORD_W = 32;
  localparam int OP_W   = 6;
  localparam int FN_W   = 6;
  localparam int FMT_W  = 5;
  localparam int WT_W   = 8;
  localparam int OP_N   = 1 << OP_W;
  localparam int FN_N   = 1 << FN_W;
  localparam int FMT_N  = 1 << FMT_W;
  localparam int CFG_AW = 8;

  localparam logic [OP_W-1:0] OP_SPECIAL = 6'h00;
  localparam logic [OP_W-1:0] OP_COP1    = 6'h11;

  localparam logic [CFG_AW-1:0] A_OPM_LO  = 8'h00;
  localparam logic [CFG_AW-1:0] A_OPM_HI  = 8'h01;
  localparam logic [CFG_AW-1:0] A_FNM_LO  = 8'h02;
  localparam logic [CFG_AW-1:0] A_FNM_HI  = 8'h03;
  localparam logic [CFG_AW-1:0] A_FMTM    = 8'h04;
  localparam logic [CFG_AW-1:0] A_OPW_BASE = 8'h40;
  localparam logic [CFG_AW-1:0] A_FNW_BASE = 8'h80;

  typedef logic [OP_N-1:0][WT_W-1:0] op_wt_tbl_t;
  typedef logic [FN_N-1:0][WT_W-1:0] fn_wt_tbl_t;
endpackage

// File: rtl/icf_cfg_regs.sv
module icf_cfg_regs
  import icf_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we,
  input  logic [CFG_AW-1:0]   cfg_addr,
  input  logic [WORD_W-1:0]   cfg_wdata,
  output logic [OP_N-1:0]     op_mask,
  output logic [FN_N-1:0]     fn_mask,
  output logic [FMT_N-1:0]    fmt_mask,
  output op_wt_tbl_t          op_wt,
  output fn_wt_tbl_t          fn_wt
);
  logic [OP_N-1:0]  op_mask_q, op_mask_d;
  logic [FN_N-1:0]  fn_mask_q, fn_mask_d;
  logic [FMT_N-1:0] fmt_mask_q, fmt_mask_d;
  logic             mask_en;

  always_comb begin
    op_mask_d  = op_mask_q;
    fn_mask_d  = fn_mask_q;
    fmt_mask_d = fmt_mask_q;
    mask_en    = 1'b0;
    if (cfg_we) begin
      unique case (cfg_addr)
        A_OPM_LO: begin op_mask_d[31:0]  = cfg_wdata; mask_en = 1'b1; end
        A_OPM_HI: begin op_mask_d[63:32] = cfg_wdata; mask_en = 1'b1; end
        A_FNM_LO: begin fn_mask_d[31:0]  = cfg_wdata; mask_en = 1'b1; end
        A_FNM_HI: begin fn_mask_d[63:32] = cfg_wdata; mask_en = 1'b1; end
        A_FMTM:   begin fmt_mask_d       = cfg_wdata[FMT_N-1:0]; mask_en = 1'b1; end
        default:  mask_en = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_mask_q  <= '1;
      fn_mask_q  <= '1;
      fmt_mask_q <= '1;
    end else if (mask_en) begin
      op_mask_q  <= op_mask_d;
      fn_mask_q  <= fn_mask_d;
      fmt_mask_q <= fmt_mask_d;
    end
  end

  for (genvar i = 0; i < OP_N; i++) begin : g_opw
    logic hit;
    assign hit = cfg_we && (cfg_addr == (A_OPW_BASE + CFG_AW'(i)));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   op_wt[i] <= '0;
      else if (hit) op_wt[i] <= cfg_wdata[WT_W-1:0];
    end
  end

  for (genvar i = 0; i < FN_N; i++) begin : g_fnw
    logic hit;
    assign hit = cfg_we && (cfg_addr == (A_FNW_BASE + CFG_AW'(i)));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   fn_wt[i] <= '0;
      else if (hit) fn_wt[i] <= cfg_wdata[WT_W-1:0];
    end
  end

  assign op_mask  = op_mask_q;
  assign fn_mask  = fn_mask_q;
  assign fmt_mask = fmt_mask_q;

  // R11: a write to an unmapped address leaves the masks alone
  a_r11_unmapped_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_addr > A_FMTM && cfg_addr < A_OPW_BASE)
      |=> ($stable(op_mask_q) && $stable(fn_mask_q) && $stable(fmt_mask_q)));
endmodule

// File: rtl/icf_classify.sv
module icf_classify
  import icf_pkg::*;
(
  input  logic [OP_W-1:0]   op,
  input  logic [FN_W-1:0]   fn,
  input  logic [FMT_W-1:0]  fmt,
  input  logic [OP_N-1:0]   op_mask,
  input  logic [FN_N-1:0]   fn_mask,
  input  logic [FMT_N-1:0]  fmt_mask,
  input  op_wt_tbl_t        op_wt,
  input  fn_wt_tbl_t        fn_wt,
  output logic              legal,
  output logic [WT_W-1:0]   weight
);
  logic is_reg_fmt, is_cop;
  logic op_ok, fn_ok, fmt_ok;

  always_comb begin
    is_reg_fmt = (op == OP_SPECIAL);
    is_cop     = (op == OP_COP1);
    op_ok      = op_mask[op];
    fn_ok      = !is_reg_fmt || fn_mask[fn];
    fmt_ok     = !is_cop || fmt_mask[fmt];
    legal      = op_ok && fn_ok && fmt_ok;
    weight     = is_reg_fmt ? fn_wt[fn] : op_wt[op];
  end
endmodule

// File: rtl/icf_rank_accum.sv
module icf_rank_accum
  import icf_pkg::*;
#(
  parameter int MAX_CAND = 16,
  localparam int CNT_W   = $clog2(MAX_CAND + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              beat,
  input  logic              last,
  input  logic [WORD_W-1:0] word,
  input  logic              legal,
  input  logic [WT_W-1:0]   weight,
  output logic              res_valid,
  output logic [WORD_W-1:0] res_word,
  output logic              res_unique,
  output logic              res_ambig,
  output logic              res_fail,
  output logic [CNT_W-1:0]  res_count
);
  logic [CNT_W-1:0]  beat_q, beat_d;
  logic [CNT_W-1:0]  lcnt_q, lcnt_d, lcnt_nxt;
  logic              have_q, have_d, have_nxt;
  logic [WT_W-1:0]   bwt_q, bwt_d, bwt_nxt;
  logic [WORD_W-1:0] bword_q, bword_d, bword_nxt;
  logic              close, take, st_en;

  logic              rv_q;
  logic [WORD_W-1:0] rw_q, rw_d;
  logic              ru_q, ru_d, ra_q, ra_d, rf_q, rf_d;
  logic [CNT_W-1:0]  rc_q, rc_d;

  // next-state: running best of the open event
  always_comb begin
    close     = beat && (last || beat_q == CNT_W'(MAX_CAND - 1));
    take      = beat && legal && (!have_q || weight > bwt_q);
    lcnt_nxt  = lcnt_q + CNT_W'(beat && legal);
    have_nxt  = have_q || take;
    bwt_nxt   = take ? weight : bwt_q;
    bword_nxt = take ? word : bword_q;
    st_en     = beat;
    if (close) begin
      beat_d  = '0;
      lcnt_d  = '0;
      have_d  = 1'b0;
      bwt_d   = '0;
      bword_d = '0;
    end else begin
      beat_d  = beat_q + CNT_W'(1);
      lcnt_d  = lcnt_nxt;
      have_d  = have_nxt;
      bwt_d   = bwt_nxt;
      bword_d = bword_nxt;
    end
    rw_d = have_nxt ? bword_nxt : '0;
    rc_d = lcnt_nxt;
    ru_d = (lcnt_nxt == CNT_W'(1));
    ra_d = (lcnt_nxt > CNT_W'(1));
    rf_d = (lcnt_nxt == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      beat_q  <= '0;
      lcnt_q  <= '0;
      have_q  <= 1'b0;
      bwt_q   <= '0;
      bword_q <= '0;
    end else if (st_en) begin
      beat_q  <= beat_d;
      lcnt_q  <= lcnt_d;
      have_q  <= have_d;
      bwt_q   <= bwt_d;
      bword_q <= bword_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rv_q <= 1'b0;
    else        rv_q <= close;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rw_q <= '0;
      ru_q <= 1'b0;
      ra_q <= 1'b0;
      rf_q <= 1'b0;
      rc_q <= '0;
    end else if (close) begin
      rw_q <= rw_d;
      ru_q <= ru_d;
      ra_q <= ra_d;
      rf_q <= rf_d;
      rc_q <= rc_d;
    end
  end

  assign res_valid  = rv_q;
  assign res_word   = rw_q;
  assign res_unique = ru_q;
  assign res_ambig  = ra_q;
  assign res_fail   = rf_q;
  assign res_count  = rc_q;

  // R10: the open-event beat counter never reaches the cap
  a_r10_beat_cap: assert property (@(posedge clk) disable iff (!rst_n)
    beat_q < CNT_W'(MAX_CAND));

  // R5: one outcome per result, and the count fits the event size
  a_r5_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> ($onehot({res_unique, res_ambig, res_fail}) &&
                   res_count <= CNT_W'(MAX_CAND)));

  // R9: a failed event carries no word and no count
  a_r9_fail_clean: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_fail) |-> (res_word == '0 && res_count == '0));

  // R7: within an event the held best weight only grows
  a_r7_best_grows: assert property (@(posedge clk) disable iff (!rst_n)
    (have_q && $past(have_q)) |-> (bwt_q >= $past(bwt_q)));
endmodule

// File: rtl/icf_candidate_select.sv
module icf_candidate_select
  import icf_pkg::*;
#(
  parameter int MAX_CAND = 16,
  localparam int CNT_W   = $clog2(MAX_CAND + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [7:0]        cfg_addr,
  input  logic [31:0]       cfg_wdata,
  input  logic              cand_valid,
  output logic              cand_ready,
  input  logic [31:0]       cand_data,
  input  logic              cand_last,
  output logic              res_valid,
  output logic [31:0]       res_word,
  output logic              res_unique,
  output logic              res_ambig,
  output logic              res_fail,
  output logic [CNT_W-1:0]  res_count
);
  logic [1:0]       rst_sync_q;
  logic             rst_int_n;
  logic [OP_N-1:0]  op_mask;
  logic [FN_N-1:0]  fn_mask;
  logic [FMT_N-1:0] fmt_mask;
  op_wt_tbl_t       op_wt;
  fn_wt_tbl_t       fn_wt;
  logic             legal;
  logic [WT_W-1:0]  weight;
  logic             beat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n  = rst_sync_q[1];
  assign cand_ready = rst_int_n;
  assign beat       = cand_valid && cand_ready;

  icf_cfg_regs u_cfg (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .op_mask   (op_mask),
    .fn_mask   (fn_mask),
    .fmt_mask  (fmt_mask),
    .op_wt     (op_wt),
    .fn_wt     (fn_wt)
  );

  icf_classify u_cls (
    .op       (cand_data[31:26]),
    .fn       (cand_data[5:0]),
    .fmt      (cand_data[25:21]),
    .op_mask  (op_mask),
    .fn_mask  (fn_mask),
    .fmt_mask (fmt_mask),
    .op_wt    (op_wt),
    .fn_wt    (fn_wt),
    .legal    (legal),
    .weight   (weight)
  );

  icf_rank_accum #(.MAX_CAND(MAX_CAND)) u_acc (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .beat       (beat),
    .last       (cand_last),
    .word       (cand_data),
    .legal      (legal),
    .weight     (weight),
    .res_valid  (res_valid),
    .res_word   (res_word),
    .res_unique (res_unique),
    .res_ambig  (res_ambig),
    .res_fail   (res_fail),
    .res_count  (res_count)
  );

  // R10: an accepted last beat produces a result in the next cycle
  a_r10_last_gives_result: assert property (@(posedge clk) disable iff (!rst_int_n)
    (cand_valid && cand_ready && cand_last) |=> res_valid);

  // R10: without an accepted beat no result appears
  a_r10_no_beat_no_result: assert property (@(posedge clk) disable iff (!rst_int_n)
    !(cand_valid && cand_ready) |=> !res_valid);

  // R6: a unique outcome reports a single legal candidate
  a_r6_unique_single: assert property (@(posedge clk) disable iff (!rst_int_n)
    (res_valid && res_unique) |-> (res_count == CNT_W'(1)));
endmodule

// File: tb/icf_candidate_select_tb_top.sv
`timescale 1ns/1ps
module icf_candidate_select_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [7:0]  cfg_addr;
  logic [31:0] cfg_wdata;
  logic        cand_valid;
  logic        cand_ready;
  logic [31:0] cand_data;
  logic        cand_last;
  logic        res_valid;
  logic [31:0] res_word;
  logic        res_unique, res_ambig, res_fail;
  logic [4:0]  res_count;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [63:0] m_op, m_fn;
  logic [31:0] m_fmt;
  logic [7:0]  w_op [64];
  logic [7:0]  w_fn [64];
  logic [31:0] cands [16];

  always #2 clk = ~clk;

  icf_candidate_select dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cand_valid(cand_valid), .cand_ready(cand_ready),
    .cand_data(cand_data), .cand_last(cand_last), .res_valid(res_valid),
    .res_word(res_word), .res_unique(res_unique), .res_ambig(res_ambig),
    .res_fail(res_fail), .res_count(res_count)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit m_legal(input logic [31:0] w);
    logic [5:0] op = w[31:26];
    bit ok = m_op[op];
    if (op == 6'h00 && !m_fn[w[5:0]])   ok = 0;
    if (op == 6'h11 && !m_fmt[w[25:21]]) ok = 0;
    return ok;
  endfunction

  function automatic int m_weight(input logic [31:0] w);
    return (w[31:26] == 6'h00) ? int'(w_fn[w[5:0]]) : int'(w_op[w[31:26]]);
  endfunction

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(posedge clk);
    #1 cfg_we = 1'b0;
    if (a == 8'h00) m_op[31:0]  = d;
    if (a == 8'h01) m_op[63:32] = d;
    if (a == 8'h02) m_fn[31:0]  = d;
    if (a == 8'h03) m_fn[63:32] = d;
    if (a == 8'h04) m_fmt       = d;
    if (a >= 8'h40 && a < 8'h80) w_op[a - 8'h40] = d[7:0];
    if (a >= 8'h80 && a < 8'hC0) w_fn[a - 8'h80] = d[7:0];
  endtask

  task automatic set_masks(input logic [63:0] op, input logic [63:0] fn, input logic [31:0] fmt);
    wr(8'h00, op[31:0]); wr(8'h01, op[63:32]);
    wr(8'h02, fn[31:0]); wr(8'h03, fn[63:32]);
    wr(8'h04, fmt);
  endtask

  task automatic run_event(input int n, input bit use_last, input string tag);
    int cnt = 0;
    int best = -1;
    int bw = 0;
    logic [31:0] exp_word;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cand_valid = 1'b1;
      cand_data  = cands[i];
      cand_last  = use_last && (i == n - 1);
      @(posedge clk);
    end
    @(negedge clk);
    cand_valid = 1'b0; cand_last = 1'b0;
    for (int i = 0; i < n; i++) begin
      if (m_legal(cands[i])) begin
        cnt++;
        if (best < 0 || m_weight(cands[i]) > bw) begin
          best = i; bw = m_weight(cands[i]);
        end
      end
    end
    exp_word = (best < 0) ? 32'h0 : cands[best];
    chk({tag, " R10 valid"}, 64'(res_valid), 64'(1));
    chk({tag, " R5 count"}, 64'(res_count), 64'(cnt));
    chk({tag, " R5 unique"}, 64'(res_unique), 64'(cnt == 1));
    chk({tag, " R5 ambig"}, 64'(res_ambig), 64'(cnt > 1));
    chk({tag, " R9 fail"}, 64'(res_fail), 64'(cnt == 0));
    chk({tag, (cnt == 0) ? " R9 word" : (cnt == 1) ? " R6 word" : " R7 R8 word"},
        64'(res_word), 64'(exp_word));
    @(negedge clk);
    chk({tag, " R10 pulse"}, 64'(res_valid), 64'(0));
  endtask

  function automatic logic [31:0] rnd_word();
    int s = $urandom_range(0, 9);
    logic [5:0] op = (s < 3) ? 6'h00 : (s < 5) ? 6'h11 : 6'($urandom);
    return {op, 26'($urandom)};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    m_op = '1; m_fn = '1; m_fmt = '1;
    for (int i = 0; i < 64; i++) begin w_op[i] = 0; w_fn[i] = 0; end
    rst_n = 1'b0; cfg_we = 0; cfg_addr = 0; cfg_wdata = 0;
    cand_valid = 0; cand_data = 0; cand_last = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 res_valid", 64'(res_valid), 64'(0));
    chk("R1 cand_ready", 64'(cand_ready), 64'(1));

    // R1 R8: all legal, zero weights -> first wins
    cands[0] = {6'h23, 26'h1}; cands[1] = {6'h2b, 26'h2}; cands[2] = {6'h00, 26'h20};
    run_event(3, 1, "R1 R8 default");

    // R2: opcode 0x23 disallowed
    set_masks(~(64'h1 << 6'h23), '1, '1);
    cands[0] = {6'h23, 26'h5}; cands[1] = {6'h2b, 26'h7};
    run_event(2, 1, "R2 opmask");

    // R3: funct 0x0d disallowed in register format
    set_masks('1, ~(64'h1 << 6'h0d), '1);
    cands[0] = {6'h00, 20'h0, 6'h0d}; cands[1] = {6'h00, 20'h3, 6'h20};
    run_event(2, 1, "R3 fnmask");

    // R4: fmt 0x10 disallowed for coprocessor
    set_masks('1, '1, ~(32'h1 << 5'h10));
    cands[0] = {6'h11, 5'h10, 21'h4}; cands[1] = {6'h11, 5'h11, 21'h4};
    run_event(2, 1, "R4 fmtmask");

    // R7 R11: weights pick the load
    set_masks('1, '1, '1);
    wr(8'h40 + 8'h23, 32'd200); wr(8'h40 + 8'h08, 32'd10); wr(8'h80 + 8'h20, 32'd50);
    wr(8'h20, 32'hFFFF_FFFF); // R11 unmapped, no effect
    cands[0] = {6'h08, 26'h9}; cands[1] = {6'h00, 20'h1, 6'h20}; cands[2] = {6'h23, 26'hA};
    run_event(3, 1, "R7 R11 rank");

    // R8: tie goes to earliest
    cands[0] = {6'h00, 20'h7, 6'h20}; cands[1] = {6'h00, 20'h8, 6'h20};
    run_event(2, 1, "R8 tie");

    // R9: none legal
    set_masks(64'h1, 64'h0, '1);
    cands[0] = {6'h00, 26'h20}; cands[1] = {6'h2b, 26'h1};
    run_event(2, 1, "R9 none");

    // R10: 16 beats without last
    set_masks('1, '1, '1);
    for (int i = 0; i < 16; i++) cands[i] = rnd_word();
    run_event(16, 0, "R10 cap");

    for (int e = 0; e < 300; e++) begin
      if (e % 20 == 0) begin
        set_masks({$urandom | $urandom, $urandom | $urandom},
                  {$urandom | $urandom, $urandom | $urandom}, $urandom | $urandom);
        for (int i = 0; i < 64; i++) begin
          wr(8'h40 + 8'(i), {24'h0, 8'($urandom)});
          wr(8'h80 + 8'(i), {24'h0, 8'($urandom_range(0, 3))});
        end
      end
      begin
        int n = $urandom_range(1, 16);
        for (int i = 0; i < n; i++) cands[i] = rnd_word();
        run_event(n, 1, "rand R2 R3 R4 R7");
      end
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule